// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM's contents alive. It counts clock cycles since the last refresh. When the count reaches a request point, it asks the main memory controller for the command bus. Once the controller grants the bus, the block issues one auto-refresh command and then hands the bus back. On a power-saving request it takes the bus, issues the self-refresh command with the clock enable driven low, and keeps the clock enable low for at least the minimum row-active time. When an exit is requested, it raises the clock enable. It then issues NOP commands for the exit-recovery time, which is never less than two clocks, before it releases the bus.

Every time limit is a parameter in picoseconds. The block converts each limit to cycles by dividing by the clock period and rounding up. The main controller watches `bus_own` and, while it is high, passes this block's command pins to the device. A request is raised a configurable number of cycles before the refresh interval runs out, which leaves the controller time to finish its current access. The interval counter starts again when an auto refresh is issued, and again when the recovery after self refresh ends.

Top module: `sdram_refresh_seq`

## Requirements
- R1: During reset and in the first cycle after it, `cke` is 1, `bus_own` is 0, `ref_req` is 0 and the command pins show NOP. NOP is `cs_n`,`ras_n`,`cas_n`,`we_n` = 0,1,1,1.
- R2: `ref_req` rises exactly REQ_AT cycles after the last of these edges: the reset edge, an auto-refresh edge, or the edge that ends self-refresh recovery. REQ_AT = ceil(T_REFI_PS/CLK_PERIOD_PS) − REQ_LEAD_CYC.
- R3: If `ref_gnt` is sampled high while `ref_req` is high, the next edge drives the auto-refresh encoding 0,0,0,1 with `cke` 1 and `bus_own` 1 for exactly one cycle. `ref_req` falls on that same edge, and `bus_own` falls on the edge after it.
- R4: `ref_gnt` has no effect while `ref_req` is low: no command is issued and `bus_own` stays 0.
- R5: `sr_enter_req` sampled while the bus is released drives the refresh encoding with `cke` 0 and `bus_own` 1 on the next edge. It takes priority over a grant in the same cycle.
- R6: `cke` stays low for at least RAS = ceil(T_RAS_PS/CLK_PERIOD_PS) cycles. An exit request that arrives earlier is held, and `cke` rises exactly RAS cycles after the entry edge.
- R7: An exit request that arrives after the dwell has elapsed makes `cke` rise on the next edge.
- R8: After `cke` rises, the pins show NOP with `bus_own` 1 for XSR = max(2, ceil(T_XSR_PS/CLK_PERIOD_PS)) cycles. `bus_own` then falls.
- R9: `sr_exit_req` while the block is not in self refresh, and `sr_enter_req` while it is, are ignored.
- R10: While `bus_own` is 0, the pins show NOP and `cke` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_enter_req | input | 1 | Request to enter self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh |
| ref_gnt | input | 1 | Bus grant from the main controller |
| ref_req | output | 1 | Auto refresh is due; asks for the bus |
| bus_own | output | 1 | This block drives the SDRAM command pins |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The bench goes after four corner cases.

- **Early exit request.** An exit request arrives one cycle after entry. A design that acts on it at once would cut the self-refresh dwell short, and `cke` would rise before RAS cycles have passed.
- **Short recovery time.** A second instance has a recovery time of under one clock. If the two-clock floor were missing, that instance would release the bus after one cycle.
- **Entry and grant together.** Entry and a grant arrive in the same cycle while a refresh is pending. A design with the wrong priority would issue an auto refresh instead of entering self refresh.
- **Interval restart.** The bench times the next request from the end of recovery. A counter that did not restart there would request too early or too late.

// File: rtl/sdram_rseq_pkg.sv
package sdram_rseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AUTO_REF,
    ST_SR_ENTER,
    ST_SR_HOLD,
    ST_SR_EXIT_NOP
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  // Time limit in ps to whole clock cycles, rounded up.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned tck_ps);
    return (t_ps + tck_ps - 1) / tck_ps;
  endfunction

endpackage

// File: rtl/sdram_ref_interval.sv
// Refresh deadline counter: due rises LIMIT edges after the last clear.
module sdram_ref_interval #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic due
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
      if (cnt == CW'(LIMIT - 1)) due <= 1'b1;
    end
  end
endmodule

// File: rtl/sdram_hold_cnt.sv
// Loadable down counter shared by the self-refresh dwell and the exit recovery.
module sdram_hold_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_cmd_out.sv
// Output register stage for the SDRAM command pins, clock enable and bus ownership.
module sdram_cmd_out
  import sdram_rseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cmd_pins_t pins_d,
  input  logic      cke_d,
  input  logic      own_d,
  output cmd_pins_t pins_q,
  output logic      cke_q,
  output logic      own_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= PINS_NOP;
      cke_q  <= 1'b1;
      own_q  <= 1'b0;
    end else begin
      pins_q <= pins_d;
      cke_q  <= cke_d;
      own_q  <= own_d;
    end
  end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_rseq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_REFI_PS     = 15_625_000,
  parameter int unsigned T_RAS_PS      = 42_000,
  parameter int unsigned T_XSR_PS      = 70_000,
  parameter int unsigned REQ_LEAD_CYC  = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  input  logic ref_gnt,
  output logic ref_req,
  output logic bus_own,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned REFI_CYC = ps_to_cyc(T_REFI_PS, CLK_PERIOD_PS);
  localparam int unsigned REQ_AT   = (REFI_CYC > REQ_LEAD_CYC) ? REFI_CYC - REQ_LEAD_CYC : 1;
  localparam int unsigned RAS_RAW  = ps_to_cyc(T_RAS_PS, CLK_PERIOD_PS);
  localparam int unsigned RAS_CYC  = (RAS_RAW < 1) ? 1 : RAS_RAW;
  localparam int unsigned XSR_RAW  = ps_to_cyc(T_XSR_PS, CLK_PERIOD_PS);
  localparam int unsigned XSR_CYC  = (XSR_RAW < 2) ? 2 : XSR_RAW;
  localparam int unsigned HOLD_MAX = (RAS_CYC > XSR_CYC) ? RAS_CYC : XSR_CYC;
  localparam int unsigned HW       = $clog2(HOLD_MAX + 1);

  seq_state_e state, state_n;
  logic       exit_pend;
  logic       ref_due;
  logic       tmr_clr;
  logic       hold_load;
  logic [HW-1:0] hold_val;
  logic       hold_zero;
  cmd_pins_t  pins_d, pins_q;
  logic       cke_d, own_d;
  logic       in_sr;

  assign in_sr = (state == ST_SR_ENTER) || (state == ST_SR_HOLD) || (state == ST_SR_EXIT_NOP);

  // Deadline restarts on an issued refresh and is held cleared through self refresh,
  // so it counts from the edge where recovery ends.
  assign tmr_clr = (state_n == ST_AUTO_REF) || in_sr;

  sdram_ref_interval #(.LIMIT(REQ_AT)) u_interval (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .due (ref_due)
  );

  sdram_hold_cnt #(.W(HW)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (hold_load),
    .load_val (hold_val),
    .zero     (hold_zero)
  );

  always_comb begin
    state_n   = state;
    hold_load = 1'b0;
    hold_val  = '0;
    pins_d    = PINS_NOP;
    cke_d     = 1'b1;
    own_d     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (sr_enter_req) begin
          state_n   = ST_SR_ENTER;
          pins_d    = PINS_REFRESH;
          cke_d     = 1'b0;
          own_d     = 1'b1;
          hold_load = 1'b1;
          hold_val  = HW'(RAS_CYC - 1);
        end else if (ref_due && ref_gnt) begin
          state_n = ST_AUTO_REF;
          pins_d  = PINS_REFRESH;
          own_d   = 1'b1;
        end
      end
      ST_AUTO_REF: begin
        state_n = ST_IDLE;
      end
      ST_SR_ENTER: begin
        state_n = ST_SR_HOLD;
        cke_d   = 1'b0;
        own_d   = 1'b1;
      end
      ST_SR_HOLD: begin
        cke_d = 1'b0;
        own_d = 1'b1;
        if (hold_zero && (exit_pend || sr_exit_req)) begin
          state_n   = ST_SR_EXIT_NOP;
          cke_d     = 1'b1;
          hold_load = 1'b1;
          hold_val  = HW'(XSR_CYC - 1);
        end
      end
      ST_SR_EXIT_NOP: begin
        own_d = 1'b1;
        if (hold_zero) begin
          state_n = ST_IDLE;
          own_d   = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      exit_pend <= 1'b0;
    end else begin
      state <= state_n;
      if (state_n == ST_SR_EXIT_NOP || !in_sr) exit_pend <= 1'b0;
      else if (sr_exit_req)                    exit_pend <= 1'b1;
    end
  end

  sdram_cmd_out u_out (
    .clk    (clk),
    .rst    (rst),
    .pins_d (pins_d),
    .cke_d  (cke_d),
    .own_d  (own_d),
    .pins_q (pins_q),
    .cke_q  (cke),
    .own_q  (bus_own)
  );

  assign cs_n    = pins_q.cs_n;
  assign ras_n   = pins_q.ras_n;
  assign cas_n   = pins_q.cas_n;
  assign we_n    = pins_q.we_n;
  assign ref_req = ref_due && (state == ST_IDLE);

endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk #(
  parameter int unsigned RAS_CYC = 11,
  parameter int unsigned XSR_CYC = 18
) (
  input logic clk,
  input logic rst,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic bus_own,
  input logic ref_req
);
  logic [15:0] low_cnt;
  logic [15:0] nop_cnt;
  logic        win;
  logic        is_ref, is_nop;

  assign is_ref = !cs_n && !ras_n && !cas_n && we_n;
  assign is_nop = !cs_n && ras_n && cas_n && we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      nop_cnt <= '0;
      win     <= 1'b0;
    end else begin
      if (!cke) low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1;
      else      low_cnt <= '0;
      if (!cke) begin
        win     <= 1'b1;
        nop_cnt <= '0;
      end else if (win && bus_own) begin
        nop_cnt <= (nop_cnt == 16'hFFFF) ? nop_cnt : nop_cnt + 1'b1;
      end else if (!bus_own) begin
        win <= 1'b0;
      end
    end
  end

  a_r6_cke_low_dwell: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (low_cnt >= 16'(RAS_CYC)));

  a_r8_exit_nop_floor: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_own) && win) |-> (nop_cnt >= 16'(XSR_CYC)));

  a_r3_refresh_single: assert property (@(posedge clk) disable iff (rst)
    (is_ref && cke) |=> is_nop);

  a_r5_sref_encoding: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> (is_ref && bus_own));

  a_r10_released_nop: assert property (@(posedge clk) disable iff (rst)
    !bus_own |-> (is_nop && cke));

  a_r2_req_while_released: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> !bus_own);

  a_r8_exit_pins_nop: assert property (@(posedge clk) disable iff (rst)
    ($rose(cke)) |-> (is_nop && bus_own));
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
  .RAS_CYC (RAS_CYC),
  .XSR_CYC (XSR_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cke     (cke),
  .cs_n    (cs_n),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .we_n    (we_n),
  .bus_own (bus_own),
  .ref_req (ref_req)
);

// File: tb/sdram_refresh_seq_bench.sv
`timescale 1ns/1ps
module sdram_refresh_seq_bench;
  localparam int CLK_PS  = 4000;
  localparam int REFI_PS = 400_000;
  localparam int RAS_PS  = 42_000;
  localparam int XSR_PS  = 70_000;
  localparam int LEAD    = 10;
  localparam int LIMIT   = (REFI_PS + CLK_PS - 1) / CLK_PS - LEAD;  // 90
  localparam int RAS     = (RAS_PS + CLK_PS - 1) / CLK_PS;          // 11
  localparam int XSR     = (XSR_PS + CLK_PS - 1) / CLK_PS;          // 18

  localparam int EV_REQ = 0, EV_OWN = 1, EV_AREF = 2, EV_SREF = 3, EV_CKEHI = 4, EV_REL = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sr_enter_req = 1'b0, sr_exit_req = 1'b0, ref_gnt = 1'b0;
  logic ref_req, bus_own, cke, cs_n, ras_n, cas_n, we_n;
  logic s_enter = 1'b0, s_exit = 1'b0;
  logic s_req, s_own, s_cke, s_cs_n, s_ras_n, s_cas_n, s_we_n;

  always #2 clk = ~clk;

  sdram_refresh_seq #(
    .CLK_PERIOD_PS(CLK_PS), .T_REFI_PS(REFI_PS), .T_RAS_PS(RAS_PS),
    .T_XSR_PS(XSR_PS), .REQ_LEAD_CYC(LEAD)
  ) u_sdram_refresh_seq (
    .clk(clk), .rst(rst), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .bus_own(bus_own), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  // Recovery below one clock: the two-cycle floor applies.
  sdram_refresh_seq #(
    .CLK_PERIOD_PS(CLK_PS), .T_REFI_PS(REFI_PS), .T_RAS_PS(RAS_PS),
    .T_XSR_PS(1000), .REQ_LEAD_CYC(LEAD)
  ) u_sdram_refresh_seq_short (
    .clk(clk), .rst(rst), .sr_enter_req(s_enter), .sr_exit_req(s_exit),
    .ref_gnt(1'b0), .ref_req(s_req), .bus_own(s_own), .cke(s_cke),
    .cs_n(s_cs_n), .ras_n(s_ras_n), .cas_n(s_cas_n), .we_n(s_we_n)
  );

  typedef struct {
    int    kind;
    int    cyc;
    string tag;
  } exp_t;

  exp_t expq[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  logic p_req = 1'b0, p_own = 1'b0, p_cke = 1'b1;
  int   next_req;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp_v, cyc);
    end
  endtask

  task automatic push(input int k, input int c, input string tag);
    exp_t e;
    e.kind = k; e.cyc = c; e.tag = tag;
    expq.push_back(e);
  endtask

  // Monitor-side: retire an observed event against the scoreboard.
  task automatic match_ev(input int k);
    int idx = -1;
    int near = -1;
    string tg = "R9";
    foreach (expq[i]) begin
      if (idx < 0 && expq[i].kind == k && expq[i].cyc == cyc) idx = i;
      if (near < 0 && expq[i].kind == k) near = i;
    end
    checks++;
    if (idx >= 0) begin
      expq.delete(idx);
    end else begin
      errors++;
      if (near >= 0) tg = expq[near].tag;
      $display("FAIL %s: event kind %0d at cycle actual=%0d expected=%0d", tg, k, cyc,
               (near >= 0) ? expq[near].cyc : -1);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (ref_req && !p_req)                     match_ev(EV_REQ);
      if (bus_own && !p_own)                     match_ev(EV_OWN);
      if (!cs_n && !ras_n && !cas_n && we_n && cke)           match_ev(EV_AREF);
      if (!cs_n && !ras_n && !cas_n && we_n && !cke && p_cke) match_ev(EV_SREF);
      if (cke && !p_cke)                         match_ev(EV_CKEHI);
      if (!bus_own && p_own)                     match_ev(EV_REL);
    end
    p_req = ref_req; p_own = bus_own; p_cke = cke;
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Grant delay cycles after the request appears; R2 and R3 expectations.
  task automatic do_refresh(input int delay);
    int a;
    wait_until(next_req + delay);
    ref_gnt = 1'b1;
    a = cyc + 1;
    push(EV_OWN, a, "R3");
    push(EV_AREF, a, "R3");
    push(EV_REL, a + 1, "R3");
    push(EV_REQ, a + LIMIT, "R2");
    next_req = a + LIMIT;
    @(negedge clk);
    ref_gnt = 1'b0;
  endtask

  initial begin
    int k, e, x, c3;
    repeat (4) @(negedge clk);
    // R1: state while reset is held
    chk(cke === 1'b1, "R1", "cke in reset", cke, 1);
    chk(bus_own === 1'b0, "R1", "bus_own in reset", bus_own, 0);
    k = cyc;
    rst = 1'b0;
    @(negedge clk);
    chk(ref_req === 1'b0, "R1", "ref_req after reset", ref_req, 0);
    chk({cs_n, ras_n, cas_n, we_n} === 4'b0111, "R1", "NOP pins after reset",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    p_req = ref_req; p_own = bus_own; p_cke = cke;
    mon_en = 1'b1;
    push(EV_REQ, k + LIMIT, "R2");
    next_req = k + LIMIT;

    // R8: recovery floor of two cycles on the short instance
    s_enter = 1'b1;
    e = cyc + 1;
    @(negedge clk); s_enter = 1'b0; s_exit = 1'b1;
    @(negedge clk); s_exit = 1'b0;
    x = e + RAS;
    wait_until(x - 1);
    chk(s_cke === 1'b0, "R6", "short cke before dwell end", s_cke, 0);
    wait_until(x);
    chk(s_cke === 1'b1 && s_own === 1'b1, "R8", "short cke/own at exit", {s_cke, s_own}, 3);
    wait_until(x + 1);
    chk(s_own === 1'b1, "R8", "short own second NOP cycle", s_own, 1);
    wait_until(x + 2);
    chk(s_own === 1'b0, "R8", "short own after two NOPs", s_own, 0);

    // R2/R3: refreshes with different grant delays
    do_refresh(0);
    do_refresh(5);

    // R4/R10: grant without a request
    wait_until(next_req - LIMIT + 3);
    ref_gnt = 1'b1;
    repeat (20) @(negedge clk);
    ref_gnt = 1'b0;
    chk(bus_own === 1'b0, "R4", "bus_own after stray grant", bus_own, 0);
    chk({cs_n, ras_n, cas_n, we_n, cke} === 5'b01111, "R10", "released pins NOP/cke",
        {cs_n, ras_n, cas_n, we_n, cke}, 5'b01111);

    // R5/R6: enter with a pending request and a grant together; early exit is held
    wait_until(next_req + 2);
    sr_enter_req = 1'b1; ref_gnt = 1'b1;
    e = cyc + 1;
    push(EV_OWN, e, "R5");
    push(EV_SREF, e, "R5");
    @(negedge clk);
    sr_enter_req = 1'b0; ref_gnt = 1'b0; sr_exit_req = 1'b1;
    @(negedge clk);
    sr_exit_req = 1'b0; sr_enter_req = 1'b1;   // R9: ignored inside self refresh
    @(negedge clk);
    sr_enter_req = 1'b0;
    x = e + RAS;
    push(EV_CKEHI, x, "R6");
    push(EV_REL, x + XSR, "R8");
    push(EV_REQ, x + XSR + LIMIT, "R2");
    next_req = x + XSR + LIMIT;
    wait_until(x - 1);
    chk(cke === 1'b0, "R6", "cke low through dwell", cke, 0);
    wait_until(x);
    chk(cke === 1'b1, "R6", "cke high at dwell end", cke, 1);

    // R9: exit request while not in self refresh
    wait_until(x + XSR + 5);
    sr_exit_req = 1'b1;
    @(negedge clk); sr_exit_req = 1'b0;
    @(negedge clk);
    chk(cke === 1'b1 && bus_own === 1'b0, "R9", "stray exit cke/own", {cke, bus_own}, 2);
    do_refresh(0);

    // R7/R8: late exit request
    wait_until(next_req + 1);
    sr_enter_req = 1'b1;
    e = cyc + 1;
    push(EV_OWN, e, "R5");
    push(EV_SREF, e, "R5");
    @(negedge clk); sr_enter_req = 1'b0;
    c3 = e + 30;
    wait_until(c3);
    sr_exit_req = 1'b1;
    x = c3 + 1;
    push(EV_CKEHI, x, "R7");
    push(EV_REL, x + XSR, "R8");
    push(EV_REQ, x + XSR + LIMIT, "R2");
    next_req = x + XSR + LIMIT;
    @(negedge clk); sr_exit_req = 1'b0;
    wait_until(x + 5);
    chk({cs_n, ras_n, cas_n, we_n, cke, bus_own} === 6'b011111, "R8", "recovery NOP pins",
        {cs_n, ras_n, cas_n, we_n, cke, bus_own}, 6'b011111);
    do_refresh(2);
    wait_until(next_req + 1);

    foreach (expq[i]) begin
      checks++;
      errors++;
      $display("FAIL %s: missing event kind %0d actual=none expected=%0d",
               expq[i].tag, expq[i].kind, expq[i].cyc);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung actual=%0d expected<%0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule